// File: doc/BRIEF.md
# Receive Flow-Control Character Filter

This block sits in a serial receive path, between a character deserializer and a receive FIFO that the host drains. Each incoming character can be compared with two programmable compare registers: one holds the resume (XON) code and the other the pause (XOFF) code. Option bits decide what happens on a match. The matching character can be removed from the stream or stored. It can drive a transmit-pause flag, and it can raise a receive-exception request toward the host.

The block contains a 12-entry character FIFO. A data-available request is asserted while FIFO occupancy is at or above a programmable threshold. Characters that arrive while the FIFO is full are dropped and set a sticky overrun flag.

The input stream uses valid/ready. `in_ready` is always high: the block never applies back-pressure upstream, and it drops characters instead, reporting the loss through `overrun`. The output stream also uses valid/ready. The head character is held stable while `out_valid` is high and `out_ready` is low. A character is removed on a cycle where both are high.

A three-register write port loads the option register (address 0), the XON compare value (address 1) and the XOFF compare value (address 2). The option register fields are:
- bit 0: transparency
- bit 1: compare enable
- bit 2: in-band flow-control enable
- bits 7:4: threshold

Top module: `rx_fc_filter`

## Requirements
- R1: After reset, the option and compare registers are 0x00. `tx_paused`, `exc_req`, `out_valid`, `overrun` and `data_req` are low, `exc_code` is 00 and `in_ready` is high.
- R2: While option bit 1 (compare enable) is 0, no character counts as a match. Every character is stored, `tx_paused` does not change and no exception is raised.
- R3: While bits 1 and 2 are both set, an accepted character equal to the XON register clears `tx_paused`, and one equal to the XOFF register sets it. The change is visible the cycle after acceptance. If both registers hold the same value, XON wins.
- R4: While bit 2 (in-band flow control) is 0, matches leave `tx_paused` unchanged.
- R5: While bits 0 and 1 are set (transparent), a matching character is not written to the FIFO and raises no exception. It still acts on `tx_paused` when bit 2 is set.
- R6: While bit 1 is set and bit 0 is clear, a matching character is written to the FIFO and sets `exc_req` the next cycle. `exc_code` is 01 for an XON match and 10 for an XOFF match, and the latest match overwrites it.
- R7: `exc_req` stays high until a one-cycle `exc_ack` pulse, which clears it the following cycle. A new match in the same cycle as the ack wins.
- R8: `data_req` is high exactly while FIFO occupancy is greater than or equal to option bits 7:4, with a threshold code of 0 treated as 1.
- R9: The FIFO returns stored characters in arrival order. It removes one per cycle where `out_valid` and `out_ready` are both high.
- R10: With 12 characters held, a further accepted character is dropped and `overrun` goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Received character present |
| in_ready | output | 1 | Always 1; no back-pressure |
| in_data | input | 8 | Received character |
| out_valid | output | 1 | FIFO not empty |
| out_ready | input | 1 | Host takes head character |
| out_data | output | 8 | FIFO head character |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | 0 option, 1 XON, 2 XOFF |
| cfg_wdata | input | 8 | Register write data |
| exc_ack | input | 1 | One-cycle exception clear pulse |
| exc_req | output | 1 | Receive-exception request |
| exc_code | output | 2 | 01 XON match, 10 XOFF match |
| tx_paused | output | 1 | Transmitter pause flag |
| data_req | output | 1 | Occupancy at or above threshold |
| overrun | output | 1 | Sticky dropped-character flag |

## Verification
The assertions assume that `exc_ack` arrives only as a single-cycle pulse. The property that the ack clears the request is therefore stated only for cycles with no character arriving. The assertions also assume the host raises `out_ready` only when it wants to take the head character. The stimulus drives every input on the falling edge and holds each strobe for exactly one cycle. It never issues an ack in the same cycle as a character, and it pops only while `out_valid` is high.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int CHAR_W = 8;

  typedef struct packed {
    logic [3:0] rx_thr;
    logic       rsv;
    logic       fc_en;
    logic       cmp_en;
    logic       transp;
  } rxf_opt_t;

  typedef enum logic [1:0] {
    EXC_NONE = 2'b00,
    EXC_XON  = 2'b01,
    EXC_XOFF = 2'b10
  } exc_code_e;

  localparam logic [1:0] ADDR_OPT  = 2'd0;
  localparam logic [1:0] ADDR_XON  = 2'd1;
  localparam logic [1:0] ADDR_XOFF = 2'd2;
endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
  import rxf_pkg::*;
#(
  parameter int DW = CHAR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output rxf_opt_t      opt,
  output logic [DW-1:0] xon_val,
  output logic [DW-1:0] xoff_val
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt      <= '0;
      xon_val  <= '0;
      xoff_val <= '0;
    end else if (we) begin
      case (addr)
        ADDR_OPT:  opt      <= rxf_opt_t'(wdata[7:0]);
        ADDR_XON:  xon_val  <= wdata;
        ADDR_XOFF: xoff_val <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rxf_char_match.sv
module rxf_char_match
  import rxf_pkg::*;
#(
  parameter int DW = CHAR_W
) (
  input  logic          valid,
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] xon_val,
  input  logic [DW-1:0] xoff_val,
  input  rxf_opt_t      opt,
  output logic          store,
  output logic          pause_set,
  output logic          pause_clr,
  output logic          exc_set,
  output exc_code_e     exc_code
);
  logic hit_xon, hit_xoff, hit_any;

  always_comb begin
    hit_xon  = valid && opt.cmp_en && (data == xon_val);
    hit_xoff = valid && opt.cmp_en && (data == xoff_val) && !hit_xon;
    hit_any  = hit_xon || hit_xoff;

    store     = valid && !(hit_any && opt.transp);
    pause_clr = hit_xon  && opt.fc_en;
    pause_set = hit_xoff && opt.fc_en;
    exc_set   = hit_any && !opt.transp;
    exc_code  = hit_xon ? EXC_XON : (hit_xoff ? EXC_XOFF : EXC_NONE);
  end
endmodule

// File: rtl/rxf_fifo.sv
module rxf_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 12,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          drop
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          full, empty, do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign drop    = push && full;
  assign head    = mem[rptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rx_fc_filter.sv
module rx_fc_filter
  import rxf_pkg::*;
#(
  parameter int DW    = CHAR_W,
  parameter int DEPTH = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          exc_ack,
  output logic          exc_req,
  output logic [1:0]    exc_code,
  output logic          tx_paused,
  output logic          data_req,
  output logic          overrun
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = (CW > 4) ? CW : 4;

  rxf_opt_t      opt;
  logic [DW-1:0] xon_val, xoff_val;
  logic          store, pause_set, pause_clr, exc_set, drop;
  exc_code_e     hit_code;
  logic [CW-1:0] count;
  logic [TW-1:0] thr_eff;

  rxf_cfg_regs #(.DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .opt(opt), .xon_val(xon_val), .xoff_val(xoff_val)
  );

  rxf_char_match #(.DW(DW)) u_match (
    .valid(in_valid), .data(in_data), .xon_val(xon_val), .xoff_val(xoff_val),
    .opt(opt), .store(store), .pause_set(pause_set), .pause_clr(pause_clr),
    .exc_set(exc_set), .exc_code(hit_code)
  );

  rxf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(store), .push_data(in_data),
    .pop(out_ready), .head(out_data), .count(count), .drop(drop)
  );

  assign in_ready  = 1'b1;
  assign out_valid = (count != '0);
  assign thr_eff   = (opt.rx_thr == 4'd0) ? TW'(1) : TW'(opt.rx_thr);
  assign data_req  = (TW'(count) >= thr_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_paused <= 1'b0;
      exc_req   <= 1'b0;
      exc_code  <= EXC_NONE;
      overrun   <= 1'b0;
    end else begin
      if (pause_set)      tx_paused <= 1'b1;
      else if (pause_clr) tx_paused <= 1'b0;

      if (exc_set) begin
        exc_req  <= 1'b1;
        exc_code <= hit_code;
      end else if (exc_ack) begin
        exc_req  <= 1'b0;
        exc_code <= EXC_NONE;
      end

      if (drop) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_fc_filter_chk.sv
module rx_fc_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       exc_ack,
  input logic       exc_req,
  input logic [1:0] exc_code,
  input logic       tx_paused,
  input logic       data_req,
  input logic       overrun
);
  p_pause_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(tx_paused));

  p_exc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req && !exc_ack |=> exc_req);

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req && exc_ack && !in_valid |=> !exc_req);

  p_code_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> $countones(exc_code) == 1);

  p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  p_head_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_dreq_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    data_req |-> out_valid);
endmodule

bind rx_fc_filter rx_fc_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .exc_ack(exc_ack),
  .exc_req(exc_req), .exc_code(exc_code), .tx_paused(tx_paused),
  .data_req(data_req), .overrun(overrun)
);

// File: tb/sim_rx_fc_filter.sv
module sim_rx_fc_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, out_ready = 1'b0, cfg_we = 1'b0, exc_ack = 1'b0;
  logic [7:0] in_data = '0, cfg_wdata = '0;
  logic [1:0] cfg_addr = '0;
  logic       in_ready, out_valid, exc_req, tx_paused, data_req, overrun;
  logic [7:0] out_data;
  logic [1:0] exc_code;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rx_fc_filter u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .exc_ack(exc_ack), .exc_req(exc_req),
    .exc_code(exc_code), .tx_paused(tx_paused), .data_req(data_req),
    .overrun(overrun)
  );

  // kind[14:13] 0 cfg, 1 char, 2 ack | addr[12:11] | data[10:3] | exp paused, exc, dreq
  localparam int NV = 14;
  localparam logic [14:0] VEC [NV] = '{
    {2'd0, 2'd1, 8'h11, 3'b000},
    {2'd0, 2'd2, 8'h13, 3'b000},
    {2'd1, 2'd0, 8'h13, 3'b001},
    {2'd0, 2'd0, 8'h36, 3'b000},
    {2'd1, 2'd0, 8'h13, 3'b110},
    {2'd2, 2'd0, 8'h00, 3'b100},
    {2'd1, 2'd0, 8'h11, 3'b011},
    {2'd2, 2'd0, 8'h00, 3'b001},
    {2'd0, 2'd0, 8'h33, 3'b001},
    {2'd1, 2'd0, 8'h13, 3'b001},
    {2'd0, 2'd0, 8'h37, 3'b001},
    {2'd1, 2'd0, 8'h13, 3'b101},
    {2'd1, 2'd0, 8'h41, 3'b101},
    {2'd1, 2'd0, 8'h11, 3'b001}
  };

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [7:0] d);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic ack();
    exc_ack = 1'b1;
    @(negedge clk);
    exc_ack = 1'b0;
  endtask

  task automatic pop(input string req, input logic [7:0] exp);
    check(req, out_valid, 1);
    check(req, out_data, exp);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 paused", tx_paused, 0);
    check("R1 exc", exc_req, 0);
    check("R1 code", exc_code, 0);
    check("R1 valid", out_valid, 0);
    check("R1 overrun", overrun, 0);
    check("R1 dreq", data_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 in_ready", in_ready, 1);

    // table walk: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][14:13])
        2'd0:    cfg(VEC[i][12:11], VEC[i][10:3]);
        2'd1:    send(VEC[i][10:3]);
        default: ack();
      endcase
      check($sformatf("R3/R5/R6/R7 vec %0d paused", i), tx_paused, VEC[i][2]);
      check($sformatf("R6/R7 vec %0d exc", i), exc_req, VEC[i][1]);
      check($sformatf("R8 vec %0d dreq", i), data_req, VEC[i][0]);
    end

    // R8 threshold boundary with 4 held
    cfg(2'd0, 8'h57);
    check("R8 thr5", data_req, 0);
    cfg(2'd0, 8'h47);
    check("R8 thr4", data_req, 1);
    // R9 order; transparent matches absent (R5)
    pop("R9", 8'h13); pop("R9", 8'h13); pop("R9", 8'h11); pop("R5 R9", 8'h41);
    check("R9 empty", out_valid, 0);

    // R6 codes and R7 hold
    cfg(2'd0, 8'h06);
    send(8'h11);
    check("R6 xon code", exc_code, 2'b01);
    @(negedge clk);
    check("R7 held", exc_req, 1);
    ack();
    check("R7 cleared", exc_req, 0);
    send(8'h13);
    check("R6 xoff code", exc_code, 2'b10);
    check("R3 paused", tx_paused, 1);
    ack();
    pop("R6 stored", 8'h11); pop("R6 stored", 8'h13);

    // R2 compare disabled, R8 threshold code 0
    cfg(2'd0, 8'h00);
    check("R8 thr0 empty", data_req, 0);
    send(8'h11);
    check("R2 paused kept", tx_paused, 1);
    check("R2 no exc", exc_req, 0);
    check("R8 thr0 one", data_req, 1);
    pop("R2 stored", 8'h11);

    // R10 overflow
    for (int k = 0; k < 12; k++) send(8'(k));
    check("R10 no overrun", overrun, 0);
    send(8'hEE);
    check("R10 overrun", overrun, 1);
    for (int k = 0; k < 12; k++) pop("R10 R9", 8'(k));
    check("R10 drop", out_valid, 0);
    check("R10 sticky", overrun, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule